// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A power-of-two prescaler produces scaled ticks. Two independent counts then set how many scaled ticks the serial clock stays high and how many it stays low, so the duty cycle can be asymmetric. The output level follows the selected clock polarity. Each edge is marked by a one-cycle strobe, so the shift register knows when to put out the next bit and when to capture the incoming one. Which edge carries which strobe depends on the selected clock phase.

A sequencer holds `run_i` high for as long as it wants clocks. It may also set a bit count; the generator then stops by itself after exactly that many clock periods and reports this with `done_o`. All settings are captured when a burst starts, so the sequencer may prepare the next burst's settings while the current one is still running. The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle pulse.

Top module: `spi_sclk_gen`

## Requirements
- R1: While idle, `sclk_o` equals `cpol_i` one cycle after any change of `cpol_i`. After reset, `sclk_o`, `launch_o`, `sample_o` and `done_o` are all 0.
- R2: Every half period of `sclk_o` lasts a whole multiple of 2^`scale_i` system clocks, with `scale_i` from 0 to 15.
- R3: `sclk_o` stays high for `hi_i`×2^`scale_i` system clocks and low for `lo_i`×2^`scale_i` system clocks.
- R4: With `cpol_i`=0 the first edge of each period is rising and the clock rests low. With `cpol_i`=1 the first edge is falling and the clock rests high.
- R5: Each edge of `sclk_o` comes with exactly one one-cycle strobe in the same cycle. With `cpha_i`=0, `sample_o` marks the first edge of each period and `launch_o` marks the second. With `cpha_i`=1 the roles are swapped. No strobe appears without an edge.
- R6: With `bits_i`=N>0, exactly N periods are produced. `done_o` then pulses for one cycle, one trailing half period after the last edge, with no edge in that cycle. With `bits_i`=0 the clock runs until `run_i` falls.
- R7: If `hi_i` or `lo_i` is 0 when a burst would start, `run_i` is ignored. No edge and no strobe appears.
- R8: A fall of `run_i` takes effect only at the next half-period boundary. A fall during the first half lets the second edge happen and then stops. A fall during the second half lets that half run out and then stops. No `done_o` pulse follows.
- R9: After `done_o`, no further edge appears while `run_i` stays high. A new burst needs `run_i` low for at least one cycle first.
- R10: `scale_i`, `hi_i`, `lo_i`, `cpol_i`, `cpha_i` and `bits_i` are captured when a burst starts. Changing them during the burst has no effect on it.
- R11: The first edge appears on the first clock edge at which `run_i` is seen high in the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request serial clocking |
| scale_i | input | SCALE_W (4) | Prescaler exponent, divide by 2^scale_i |
| hi_i | input | HALF_W (8) | High time in scaled ticks, 0 blocks the start |
| lo_i | input | HALF_W (8) | Low time in scaled ticks, 0 blocks the start |
| cpol_i | input | 1 | Clock polarity, 1 rests high |
| cpha_i | input | 1 | Clock phase, 1 samples on the second edge |
| bits_i | input | BITS_W (6) | Periods per burst, 0 for unlimited |
| sclk_o | output | 1 | Serial clock level |
| launch_o | output | 1 | One-cycle strobe on the edge where data changes |
| sample_o | output | 1 | One-cycle strobe on the edge where data is captured |
| done_o | output | 1 | One-cycle pulse when a counted burst ends |

## Verification
The hardest cases to reach are the early stops. A fall of `run_i` only acts at a half-period boundary, so the stimulus must drop it strictly inside a chosen half. The bench does this by counting system clocks from the cycle in which it raised `run_i`, with half lengths of four and three ticks. That gives one run that stops after the second edge of the second period and one that stops after the low half of the first period. Settings captured at the start are probed by changing every setting a few cycles into a burst. The expected edge list is still the original one.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Phase of the generator: resting, first half, second half, waiting for run to drop
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_TRAIL = 2'd2,
    PH_HOLD  = 2'd3
  } sclk_phase_e;

  localparam int DEF_SCALE_W = 4;
  localparam int DEF_HALF_W  = 8;
  localparam int DEF_BITS_W  = 6;

endpackage

// File: rtl/spi_sclk_prescale.sv
// Power-of-two tick generator: one tick every 2^scale_i system clocks.
module spi_sclk_prescale #(
  parameter int SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);

  localparam int PRE_W = (1 << SCALE_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] wrap;

  // all-ones of scale_i bits; a shift past the top wraps to zero and the
  // subtraction then yields the full-width mask
  assign wrap   = (PRE_W'(1) << scale_i) - PRE_W'(1);
  assign tick_o = (cnt_q == wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/spi_sclk_halfcnt.sv
// Counts scaled ticks within one half period; end_o on the last tick.
module spi_sclk_halfcnt #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [HALF_W-1:0] len_i,
  output logic              end_o
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{HALF_W{1'b0}}, 1'b1};
  assign end_o   = tick_i && (cnt_inc == {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || end_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc[HALF_W-1:0];
    end
  end

endmodule

// File: rtl/spi_sclk_strobe_map.sv
// Assigns the launch and sample roles to the two edges of a period.
module spi_sclk_strobe_map (
  input  logic pha_i,
  input  logic lead_i,
  input  logic trail_i,
  output logic launch_o,
  output logic sample_o
);

  always_comb begin
    if (pha_i) begin
      launch_o = lead_i;
      sample_o = trail_i;
    end else begin
      launch_o = trail_i;
      sample_o = lead_i;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int SCALE_W = DEF_SCALE_W,
  parameter int HALF_W  = DEF_HALF_W,
  parameter int BITS_W  = DEF_BITS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [HALF_W-1:0]  hi_i,
  input  logic [HALF_W-1:0]  lo_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [BITS_W-1:0]  bits_i,
  output logic               sclk_o,
  output logic               launch_o,
  output logic               sample_o,
  output logic               done_o
);

  sclk_phase_e state_q, state_d;

  // settings captured at burst start
  logic [SCALE_W-1:0] scale_q;
  logic [HALF_W-1:0]  hi_q, lo_q;
  logic               cpol_q, cpha_q;
  logic [BITS_W-1:0]  bits_q, bit_cnt_q;

  logic sclk_q, launch_q, sample_q, done_q;

  logic running, tick, half_end;
  logic start_ok, load_cfg, lead_edge, trail_edge, finish, last_bit;
  logic pol_eff, pha_eff;
  logic launch_d, sample_d;
  logic [HALF_W-1:0] lead_len, trail_len, cur_len;

  assign running   = (state_q == PH_LEAD) || (state_q == PH_TRAIL);
  assign start_ok  = run_i && (hi_i != '0) && (lo_i != '0);
  // the first half is the active level: high time for cpol=0, low time for cpol=1
  assign lead_len  = cpol_q ? lo_q : hi_q;
  assign trail_len = cpol_q ? hi_q : lo_q;
  assign cur_len   = (state_q == PH_LEAD) ? lead_len : trail_len;
  assign last_bit  = (bits_q != '0) && (bit_cnt_q == bits_q - BITS_W'(1));
  assign pol_eff   = (state_q == PH_IDLE) ? cpol_i : cpol_q;
  assign pha_eff   = (state_q == PH_IDLE) ? cpha_i : cpha_q;

  spi_sclk_prescale #(.SCALE_W(SCALE_W)) u_prescale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!running),
    .scale_i (scale_q),
    .tick_o  (tick)
  );

  spi_sclk_halfcnt #(.HALF_W(HALF_W)) u_halfcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!running),
    .tick_i (tick),
    .len_i  (cur_len),
    .end_o  (half_end)
  );

  always_comb begin
    state_d    = state_q;
    load_cfg   = 1'b0;
    lead_edge  = 1'b0;
    trail_edge = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_ok) begin
          state_d   = PH_LEAD;
          load_cfg  = 1'b1;
          lead_edge = 1'b1;
        end
      end
      PH_LEAD: begin
        if (half_end) begin
          trail_edge = 1'b1;
          state_d    = run_i ? PH_TRAIL : PH_IDLE;
        end
      end
      PH_TRAIL: begin
        if (half_end) begin
          if (last_bit) begin
            finish  = 1'b1;
            state_d = PH_HOLD;
          end else if (run_i) begin
            lead_edge = 1'b1;
            state_d   = PH_LEAD;
          end else begin
            state_d = PH_IDLE;
          end
        end
      end
      PH_HOLD: begin
        if (!run_i) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  spi_sclk_strobe_map u_strobe_map (
    .pha_i    (pha_eff),
    .lead_i   (lead_edge),
    .trail_i  (trail_edge),
    .launch_o (launch_d),
    .sample_o (sample_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      scale_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      bits_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_cfg) begin
        scale_q <= scale_i;
        hi_q    <= hi_i;
        lo_q    <= lo_i;
        cpol_q  <= cpol_i;
        cpha_q  <= cpha_i;
        bits_q  <= bits_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
    end else if (load_cfg) begin
      bit_cnt_q <= '0;
    end else if (state_q == PH_TRAIL && half_end) begin
      bit_cnt_q <= bit_cnt_q + BITS_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sclk_q   <= pol_eff ^ (state_d == PH_LEAD);
      launch_q <= launch_d;
      sample_q <= sample_d;
      done_q   <= finish;
    end
  end

  assign sclk_o   = sclk_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;
  assign done_o   = done_q;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic sclk_o,
  input logic launch_o,
  input logic sample_o,
  input logic done_o
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));

  // R5
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o || sample_o) |-> (sclk_o != $past(sclk_o)));

  // R5
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  // R5
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!launch_o && !sample_o && $stable(sclk_o)));

  // R9
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && run_i) |=> (!launch_o && !sample_o));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_spi_sclk_gen_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .sclk_o   (sclk_o),
  .launch_o (launch_o),
  .sample_o (sample_o),
  .done_o   (done_o)
);

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;

  typedef struct {
    bit    is_done;
    bit    level;
    bit    samp;
    int    gap;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic [3:0] scale_i = '0;
  logic [7:0] hi_i = 8'd1;
  logic [7:0] lo_i = 8'd1;
  logic       cpol_i = 1'b0;
  logic       cpha_i = 1'b0;
  logic [5:0] bits_i = '0;
  logic       sclk_o, launch_o, sample_o, done_o;

  int  n_chk = 0;
  int  n_bad = 0;
  int  gap_cnt = 0;
  int  unexp = 0;
  bit  mon_en = 1'b0;
  bit  prev_sclk = 1'b0;
  ev_t exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  spi_sclk_gen u_spi_sclk_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .run_i    (run_i),
    .scale_i  (scale_i),
    .hi_i     (hi_i),
    .lo_i     (lo_i),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .bits_i   (bits_i),
    .sclk_o   (sclk_o),
    .launch_o (launch_o),
    .sample_o (sample_o),
    .done_o   (done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit d, input bit lv, input bit sm, input int g,
                      input string r);
    ev_t e;
    e.is_done = d; e.level = lv; e.samp = sm; e.gap = g; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic compare(input ev_t o);
    ev_t e;
    if (exp_q.size() == 0) begin
      unexp++;
      check(1'b0, "R6 R7 R9", "unexpected event (kind)", o.is_done, -1);
      return;
    end
    e = exp_q.pop_front();
    check(o.is_done == e.is_done, e.req, "event kind", o.is_done, e.is_done);
    check(o.level == e.level, e.req, "sclk level after edge (R4)", o.level, e.level);
    check(o.samp == e.samp, e.req, "sample strobe on edge (R5)", o.samp, e.samp);
    check(o.gap == e.gap, e.req, "cycles since previous event (R2 R3)", o.gap, e.gap);
  endtask

  // monitor: samples at the falling edge, away from the active edge
  always @(negedge clk) begin
    ev_t o;
    if (rst_n) begin
      gap_cnt++;
      if (mon_en) begin
        if (sclk_o != prev_sclk) begin
          check(launch_o != sample_o, "R5", "exactly one strobe on edge",
                int'(launch_o) + int'(sample_o), 1);
          o.is_done = 1'b0; o.level = sclk_o; o.samp = sample_o; o.gap = gap_cnt;
          compare(o);
          gap_cnt = 0;
        end else if (launch_o || sample_o) begin
          check(1'b0, "R5", "strobe without edge", 1, 0);
        end
        if (done_o) begin
          o.is_done = 1'b1; o.level = 1'b0; o.samp = 1'b0; o.gap = gap_cnt;
          compare(o);
          gap_cnt = 0;
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic setup(input bit pol, input bit pha, input int hi, input int lo,
                       input int s, input int n);
    @(posedge clk); #1;
    mon_en = 1'b0;
    cpol_i = pol; cpha_i = pha; hi_i = 8'(hi); lo_i = 8'(lo);
    scale_i = 4'(s); bits_i = 6'(n);
    repeat (3) @(posedge clk);
    #1;
    mon_en = 1'b1;
    check(sclk_o == pol, "R1", "idle level follows polarity", sclk_o, pol);
  endtask

  // driver: pushes the expected edge list, then raises run
  task automatic burst(input bit pol, input bit pha, input int hi, input int lo,
                       input int s, input int n, input bit perturb, input string tag);
    int lead_l, trail_l, u0;
    setup(pol, pha, hi, lo, s, n);
    lead_l  = (pol ? lo : hi) << s;
    trail_l = (pol ? hi : lo) << s;
    for (int b = 0; b < n; b++) begin
      push(1'b0, !pol, !pha, (b == 0) ? 2 : trail_l, (b == 0) ? "R11" : tag);
      push(1'b0, pol, pha, lead_l, tag);
    end
    push(1'b1, 1'b0, 1'b0, trail_l, "R6");
    gap_cnt = 0;
    run_i = 1'b1;
    if (perturb) begin
      repeat (3) @(posedge clk);
      #1;
      hi_i = 8'd9; lo_i = 8'd1; scale_i = 4'd0; cpha_i = !pha; bits_i = 6'd7;
    end
    while (exp_q.size() != 0) @(posedge clk);
    // R9: keep run high after the end; nothing may follow
    u0 = unexp;
    repeat (20) @(posedge clk);
    #1;
    check(unexp == u0, "R9", "events while run held after done", unexp - u0, 0);
    check(sclk_o == pol, "R9", "sclk rests after done", sclk_o, pol);
    run_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic zero_try(input int hi, input int lo);
    int u0;
    setup(1'b0, 1'b0, hi, lo, 0, 2);
    u0 = unexp;
    run_i = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    check(unexp == u0, "R7", "edges with a zero half time", unexp - u0, 0);
    check(sclk_o == 1'b0, "R7", "sclk idle with zero half time", sclk_o, 0);
    run_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // lead = 4, trail = 3 ticks, unlimited bits; run falls inside a chosen half
  task automatic drop_run(input bit in_lead);
    setup(1'b0, 1'b0, 4, 3, 0, 0);
    push(1'b0, 1'b1, 1'b1, 2, "R11");
    push(1'b0, 1'b0, 1'b0, 4, "R8");
    if (in_lead) begin
      push(1'b0, 1'b1, 1'b1, 3, "R8");
      push(1'b0, 1'b0, 1'b0, 4, "R8");
    end
    gap_cnt = 0;
    run_i = 1'b1;
    repeat (in_lead ? 9 : 5) @(posedge clk);
    #1;
    run_i = 1'b0;
    repeat (30) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8", "edges left after early stop", exp_q.size(), 0);
    check(sclk_o == 1'b0, "R8", "sclk idle after early stop", sclk_o, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "all", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sclk_o == 1'b0 && launch_o == 1'b0 && sample_o == 1'b0 && done_o == 1'b0,
          "R1", "outputs in reset", {sclk_o, launch_o, sample_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1: idle level tracks polarity
    cpol_i = 1'b1;
    @(posedge clk); #1;
    check(sclk_o == 1'b1, "R1", "idle sclk after cpol=1", sclk_o, 1);
    cpol_i = 1'b0;
    @(posedge clk); #1;
    check(sclk_o == 1'b0, "R1", "idle sclk after cpol=0", sclk_o, 0);

    burst(1'b0, 1'b0, 2, 3, 0, 3, 1'b0, "R3 R4 R5");   // mode 0
    burst(1'b0, 1'b1, 1, 1, 0, 2, 1'b0, "R3 R5");      // mode 1, one-cycle halves
    burst(1'b1, 1'b0, 3, 1, 2, 2, 1'b0, "R2 R4");      // mode 2, asymmetric
    burst(1'b1, 1'b1, 2, 5, 1, 3, 1'b0, "R3 R4 R5");   // mode 3
    burst(1'b0, 1'b0, 1, 2, 3, 2, 1'b0, "R2");         // prescale by 8
    burst(1'b1, 1'b1, 1, 2, 5, 1, 1'b0, "R2 R6");      // prescale by 32, one bit
    burst(1'b0, 1'b1, 3, 2, 1, 2, 1'b1, "R10");        // settings changed mid-burst
    zero_try(0, 4);
    zero_try(4, 0);
    drop_run(1'b1);
    drop_run(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule